// File: doc/BRIEF.md
# Upper-Megabyte Bank Decoder

This block steers every bus access that falls in the top quarter of the first megabyte (0xC0000 to 0xFFFFF) to exactly one target: plane VRAM, the text/sprite RAM, a small memory-mapped I/O window, the dictionary ROM, CMOS, the system ROM or main RAM. Where the access goes depends on two control ports it owns. The first is a status port whose top bit swaps the 0xC0000 to 0xEFFFF range between a video view and plain RAM. The second is a bank port with one bit that brings in the dictionary and CMOS, and one bit that overlays the system ROM on the last 32 KiB.

Target selects, the ROM address and the wait class are combinational from the address and the current control state, so they are valid in the same cycle as the strobe. The ROM windows behave differently for reads and writes. A read of an overlaid ROM window goes to the ROM. A write to the system ROM window lands in RAM underneath. A write to the dictionary window is dropped. Reads that hit nothing are flagged by a fill byte of 0xFF. The memory arrays live outside the block.

Top module: `hiram_bank_decoder`

## Requirements
- R1: `tgt_sel` has at most one bit set. The bit positions are 0 plane VRAM, 1 text/sprite RAM, 2 I/O window, 3 dictionary ROM, 4 CMOS, 5 system ROM and 6 main RAM. With neither strobe high it is zero. When both strobes are high, the access is decoded as a read.
- R2: With status bit 7 at 0 (video view), 0xC0000 to 0xC7FFF selects plane VRAM.
- R3: In the video view, 0xC8000 to 0xCAFFF selects text/sprite RAM, 0xCB000 to 0xCFF7F selects main RAM, and 0xCFF80 to 0xCFFFF selects the I/O window.
- R4: With status bit 7 at 1, every access in 0xC0000 to 0xEFFFF selects main RAM.
- R5: In the video view with bank bit 0 at 1, reads of 0xD0000 to 0xD7FFF select the dictionary ROM and writes there select nothing. 0xD8000 to 0xDFFFF selects CMOS, and 0xE0000 to 0xEFFFF selects nothing.
- R6: With bank bit 0 at 0, 0xD0000 to 0xEFFFF selects main RAM.
- R7: With bank bit 1 at 0, reads of 0xF8000 to 0xFFFFF select the system ROM and writes there select main RAM. With bank bit 1 at 1, that window is main RAM for both. 0xF0000 to 0xF7FFF is always main RAM.
- R8: `rom_addr` is 0x38000 plus address bits 14:0 for a system ROM read, address bits 14:0 for a dictionary read, and 0 otherwise.
- R9: `wait_vram` is 1 exactly when an access falls in 0xC0000 to 0xCFFFF in the video view. Otherwise it is 0, which is the RAM wait class.
- R10: A read that selects nothing drives `miss_rdata` to 0xFF. Every other cycle drives 0x00. Addresses below 0xC0000 select nothing.
- R11: An `io_rd` pulse returns the port value on `io_rdata` one cycle later, and `io_rdata` holds that value until the next read. `io_sel`=1 picks the bank port: bit 0 is the dictionary bit and bit 1 is bank bit 1 as written. `io_sel`=0 picks the status port: bit 7 is the view bit. All other bits read 0.
- R12: Synchronous reset clears the view bit, the dictionary bit and bank bit 1. This gives the video view, no dictionary and the system ROM overlaid. A port write changes the decode from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| io_sel | input | 1 | Port select: 0 status, 1 bank |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Registered port read data |
| tgt_sel | output | 7 | One-hot target select |
| rom_addr | output | 18 | ROM byte address for ROM reads |
| wait_vram | output | 1 | 1 = VRAM wait class, 0 = RAM wait class |
| miss_rdata | output | 8 | 0xFF on an unmapped read, else 0x00 |

## Verification
The decode is probed at both edges of every sub-window boundary: C7FFF/C8000, CAFFF/CB000, CFF7F/CFF80, D7FFF/D8000, DFFFF/E0000 and F7FFF/F8000. It is probed under each of the four control combinations that change the map. Sending the same address once as a read and once as a write separates the read/write-asymmetric windows (dictionary dropped, system ROM falling through to RAM) from the symmetric ones. Readback after writes with bit patterns that differ from the reset value shows both the register contents and the inverted-looking ROM bit. A reset in the middle of the run, taken with every bit set, shows that the reset values are restored.

// File: rtl/hiram_pkg.sv
package hiram_pkg;
  localparam int NUM_TGT = 7;

  typedef enum logic [2:0] {
    T_PVRAM = 3'd0,
    T_TEXT  = 3'd1,
    T_MMIO  = 3'd2,
    T_DICT  = 3'd3,
    T_CMOS  = 3'd4,
    T_SROM  = 3'd5,
    T_RAM   = 3'd6
  } tgt_e;

  // all three flags are zero after reset
  typedef struct packed {
    logic ram_view;   // 1: C0000-EFFFF is plain RAM
    logic dict_on;    // 1: dictionary + CMOS in D segment
    logic srom_off;   // 1: F8000-FFFFF is plain RAM
  } bank_cfg_t;
endpackage

// File: rtl/hiram_ctrl_regs.sv
module hiram_ctrl_regs
  import hiram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output bank_cfg_t         cfg,
  output logic [DATA_W-1:0] io_rdata
);
  localparam int VIEW_BIT = 7;
  localparam int DICT_BIT = 0;
  localparam int SROM_BIT = 1;

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (io_sel) begin
      rd_word[DICT_BIT] = cfg.dict_on;
      rd_word[SROM_BIT] = cfg.srom_off;
    end else begin
      rd_word[VIEW_BIT] = cfg.ram_view;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      io_rdata <= '0;
    end else begin
      if (io_wr) begin
        if (io_sel) begin
          cfg.dict_on  <= io_wdata[DICT_BIT];
          cfg.srom_off <= io_wdata[SROM_BIT];
        end else begin
          cfg.ram_view <= io_wdata[VIEW_BIT];
        end
      end
      if (io_rd) io_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/hiram_addr_decode.sv
module hiram_addr_decode
  import hiram_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                ROM_AW    = 18,
  parameter logic [ROM_AW-1:0] SROM_BASE = 18'h38000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  bank_cfg_t         cfg,
  output logic [NUM_TGT-1:0] sel,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               wait_vram,
  output logic [7:0]         miss_rdata
);
  localparam int SEG_LSB = ADDR_W - 4;   // 64 KiB segments
  localparam int HALF    = SEG_LSB - 1;  // 32 KiB half select

  logic [3:0]         seg;
  logic [SEG_LSB-1:0] off;
  logic               is_rd, is_wr, act, hit, in_vid;
  tgt_e               tgt;

  assign seg   = addr[ADDR_W-1:SEG_LSB];
  assign off   = addr[SEG_LSB-1:0];
  assign is_rd = rd;
  assign is_wr = wr & ~rd;
  assign act   = is_rd | is_wr;

  always_comb begin
    hit      = 1'b0;
    tgt      = T_RAM;
    rom_addr = '0;
    in_vid   = 1'b0;
    case (seg)
      4'hC: begin
        hit = 1'b1;
        if (!cfg.ram_view) begin
          in_vid = 1'b1;
          if (!off[HALF])                   tgt = T_PVRAM;
          else if (off[HALF-1:12] < 3'd3)   tgt = T_TEXT;
          else if (&off[HALF:7])            tgt = T_MMIO;
          else                              tgt = T_RAM;
        end
      end
      4'hD: begin
        if (!cfg.ram_view && cfg.dict_on) begin
          if (!off[HALF]) begin
            if (is_rd) begin
              hit      = 1'b1;
              tgt      = T_DICT;
              rom_addr = ROM_AW'(off[HALF-1:0]);
            end
          end else begin
            hit = 1'b1;
            tgt = T_CMOS;
          end
        end else begin
          hit = 1'b1;
        end
      end
      4'hE: hit = cfg.ram_view | ~cfg.dict_on;
      4'hF: begin
        hit = 1'b1;
        if (off[HALF] && !cfg.srom_off && is_rd) begin
          tgt      = T_SROM;
          rom_addr = SROM_BASE + ROM_AW'(off[HALF-1:0]);
        end
      end
      default: hit = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign sel[g] = act & hit & (tgt == tgt_e'(g));
  end

  assign wait_vram  = act & in_vid;
  assign miss_rdata = (is_rd & ~hit) ? 8'hFF : 8'h00;
endmodule

// File: rtl/hiram_bank_decoder.sv
module hiram_bank_decoder
  import hiram_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 8,
  parameter int                ROM_AW    = 18,
  parameter logic [ROM_AW-1:0] SROM_BASE = 18'h38000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic                io_sel,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  output logic [NUM_TGT-1:0]  tgt_sel,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic                wait_vram,
  output logic [7:0]          miss_rdata
);
  bank_cfg_t cfg;

  hiram_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .cfg(cfg), .io_rdata(io_rdata)
  );

  hiram_addr_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .SROM_BASE(SROM_BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .cfg(cfg),
    .sel(tgt_sel), .rom_addr(rom_addr), .wait_vram(wait_vram),
    .miss_rdata(miss_rdata)
  );
endmodule

// File: rtl/hiram_decoder_chk.sv
module hiram_decoder_chk
  import hiram_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [19:0]        bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic               io_sel,
  input logic               io_wr,
  input logic [7:0]         io_wdata,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic               wait_vram,
  input bank_cfg_t          cfg
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(tgt_sel));

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |-> tgt_sel == '0);

  p_dictwr_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && !cfg.ram_view && cfg.dict_on && bus_addr[19:15] == 5'b11010)
      |-> tgt_sel == '0);

  p_romwr_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |-> !tgt_sel[T_SROM]);

  p_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (tgt_sel[T_PVRAM] || tgt_sel[T_TEXT] || tgt_sel[T_MMIO]) |-> wait_vram);

  p_below_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr < 20'hC0000) |-> tgt_sel == '0);

  p_rst_r12: assert property (@(posedge clk) rst |=> cfg == '0);

  p_bankwr_r12: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_sel) |=> cfg.dict_on == $past(io_wdata[0]));
endmodule

bind hiram_bank_decoder hiram_decoder_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .io_sel(io_sel), .io_wr(io_wr), .io_wdata(io_wdata), .tgt_sel(tgt_sel),
  .wait_vram(wait_vram), .cfg(cfg)
);

// File: tb/hiram_bank_decoder_tb.sv
module hiram_bank_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [6:0]  tgt_sel;
  logic [17:0] rom_addr;
  logic        wait_vram;
  logic [7:0]  miss_rdata;

  int n_total = 0;
  int n_bad   = 0;

  // model of the control state
  bit m_view = 0, m_dict = 0, m_soff = 0;

  typedef struct {
    logic [6:0]  sel;
    logic [17:0] rom;
    logic        wv;
    logic [7:0]  miss;
    string       tag;
    logic [19:0] a;
  } item_t;

  item_t q[$];

  always #5 clk = ~clk;

  hiram_bank_decoder u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .tgt_sel(tgt_sel), .rom_addr(rom_addr),
    .wait_vram(wait_vram), .miss_rdata(miss_rdata)
  );

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic item_t predict(logic [19:0] a, bit rd, bit wr, string tag);
    item_t it;
    bit r = rd;
    bit w = wr && !rd;
    int t = -1;
    it.rom = '0; it.wv = 0; it.tag = tag; it.a = a;
    if (r || w) begin
      if (a < 20'hC0000) t = -1;
      else if (a < 20'hD0000) begin
        if (!m_view) begin
          it.wv = 1;
          if (a < 20'hC8000)       t = 0;
          else if (a < 20'hCB000)  t = 1;
          else if (a >= 20'hCFF80) t = 2;
          else                     t = 6;
        end else t = 6;
      end else if (a < 20'hF0000) begin
        if (!m_view && m_dict) begin
          if (a < 20'hD8000) begin
            if (r) begin t = 3; it.rom = 18'(a - 20'hD0000); end
          end else if (a < 20'hE0000) t = 4;
        end else t = 6;
      end else if (a >= 20'hF8000 && !m_soff && r) begin
        t = 5; it.rom = 18'h38000 + 18'(a - 20'hF8000);
      end else t = 6;
    end
    it.sel  = (t >= 0) ? 7'(1 << t) : 7'd0;
    it.miss = (r && t < 0) ? 8'hFF : 8'h00;
    return it;
  endfunction

  task automatic access(logic [19:0] a, bit rd, bit wr, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr;
    q.push_back(predict(a, rd, wr, tag));
  endtask

  task automatic io_write(bit s, logic [7:0] d);
    @(negedge clk);
    io_sel = s; io_wr = 1'b1; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    if (s) begin m_dict = d[0]; m_soff = d[1]; end
    else m_view = d[7];
  endtask

  task automatic io_read(bit s, logic [7:0] exp, string tag);
    @(negedge clk);
    io_sel = s; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    #2;
    check(io_rdata == exp, tag, "io_rdata", 32'(io_rdata), 32'(exp));
  endtask

  // monitor: pops each expected item while the access is on the bus
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(tgt_sel == e.sel, e.tag, $sformatf("tgt_sel @%h", e.a), 32'(tgt_sel), 32'(e.sel));
        check(rom_addr == e.rom, "R8", $sformatf("rom_addr @%h", e.a), 32'(rom_addr), 32'(e.rom));
        check(wait_vram == e.wv, "R9", $sformatf("wait_vram @%h", e.a), 32'(wait_vram), 32'(e.wv));
        check(miss_rdata == e.miss, "R10", $sformatf("miss_rdata @%h", e.a), 32'(miss_rdata), 32'(e.miss));
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state via readback and decode
    io_read(1'b1, 8'h00, "R12_bank");
    io_read(1'b0, 8'h00, "R12_status");
    access(20'hC0000, 1, 0, "R12");

    // R1 idle, both strobes, below region
    access(20'hC0000, 0, 0, "R1_idle");
    access(20'hD0000, 1, 1, "R1_both");
    access(20'hBFFFF, 1, 0, "R10_below");
    access(20'hBFFFF, 0, 1, "R10_below_wr");

    // R2 / R3 video view boundaries
    access(20'hC7FFF, 1, 0, "R2");
    access(20'hC7FFF, 0, 1, "R2_wr");
    access(20'hC8000, 1, 0, "R3_text");
    access(20'hCAFFF, 0, 1, "R3_text");
    access(20'hCB000, 1, 0, "R3_ram");
    access(20'hCFF7F, 0, 1, "R3_ram");
    access(20'hCFF80, 1, 0, "R3_mmio");
    access(20'hCFFFF, 0, 1, "R3_mmio");

    // R6 dictionary off
    access(20'hD0000, 1, 0, "R6");
    access(20'hDFFFF, 0, 1, "R6");
    access(20'hEFFFF, 1, 0, "R6");

    // R7 system ROM overlay
    access(20'hF7FFF, 1, 0, "R7_low");
    access(20'hF8000, 1, 0, "R7_rom");
    access(20'hFFFFF, 1, 0, "R7_rom");
    access(20'hF8000, 0, 1, "R7_wr");

    // R5 dictionary on
    io_write(1'b1, 8'h01);
    io_read(1'b1, 8'h01, "R11_bank");
    access(20'hD0000, 1, 0, "R5_dict");
    access(20'hD7FFF, 1, 0, "R5_dict");
    access(20'hD0000, 0, 1, "R5_dropwr");
    access(20'hD8000, 1, 0, "R5_cmos");
    access(20'hDFFFF, 0, 1, "R5_cmos");
    access(20'hE0000, 1, 0, "R5_hole");
    access(20'hEFFFF, 0, 1, "R5_hole");

    // R7 overlay off
    io_write(1'b1, 8'h03);
    io_read(1'b1, 8'h03, "R11_bank");
    access(20'hF8000, 1, 0, "R7_off");
    access(20'hFFFFF, 0, 1, "R7_off");

    // R4 RAM view, dictionary still on
    io_write(1'b0, 8'h80);
    io_read(1'b0, 8'h80, "R11_status");
    access(20'hC0000, 1, 0, "R4");
    access(20'hC8000, 0, 1, "R4");
    access(20'hCFF80, 1, 0, "R4");
    access(20'hD0000, 1, 0, "R4");
    access(20'hD0000, 0, 1, "R4");
    access(20'hE0000, 1, 0, "R4");

    // R12 write takes effect next cycle: back to video view
    io_write(1'b0, 8'h00);
    access(20'hC0000, 1, 0, "R12_next");

    // R12 mid-run reset with all bits set
    io_write(1'b1, 8'h03);
    io_write(1'b0, 8'h80);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_view = 0; m_dict = 0; m_soff = 0;
    io_read(1'b1, 8'h00, "R12_rst");
    access(20'hF8000, 1, 0, "R12_rst");
    access(20'hD0000, 1, 0, "R12_rst");

    access(20'h00000, 0, 0, "R1_idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule